// File: doc/BRIEF.md
# Two-Level Correlating Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It has two levels. The first level records the directions of recent branches. The second level is a table of saturating counters. Each counter is selected by joining a recorded outcome pattern with the low bits of the branch address. A mode pin chooses the first-level source. In global mode the source is one shift register fed by every resolved branch. In local mode it is a small table of shift registers, one per low-address slot, and each is fed only by branches that map to that slot.

A lookup request carries a branch address. It is accepted on a valid/ready handshake, and the registered taken/not-taken answer appears on a valid/ready response channel one cycle later. A lookup is accepted only while the response register is empty or is being drained in the same cycle. The response holds its value until the consumer takes it. An update request carries an address and the resolved direction. It is always accepted and is never back-pressured. It trains the selected counter and shifts the histories.

Top module: `bpred_2lvl`

## Requirements
- R1: After reset every counter holds the weakly not-taken value 2^(CTR_W-1)-1 and every history register holds zero, so every lookup made before any update predicts not-taken (pr_taken = 0).
- R2: The prediction is taken (1) exactly when the selected counter is at or above 2^(CTR_W-1). Otherwise it is not-taken (0).
- R3: A taken update increments the selected counter and stops at 2^CTR_W-1. It never wraps to zero.
- R4: A not-taken update decrements the selected counter and stops at 0. It never wraps to the maximum. From a saturated counter, one wrong outcome does not flip the prediction, and a second one does.
- R5: The counter index is {history[HIST_W-1:0], addr[PC_BITS-1:0]}, with the history in the upper bits.
- R6: On every update the global history shifts left by one, and the resolved direction (1 = taken) enters bit 0.
- R7: With use_local = 0, the index uses the global history, so an update on any branch changes the prediction path of every address.
- R8: With use_local = 1, the index uses the local history entry selected by addr[LHT_W-1:0]. An update changes only the entry of its own slot. Both history kinds are updated in either mode.
- R9: A lookup and an update that hit the same counter in the same cycle return the prediction from before that update.
- R10: lk_ready is high when pr_valid is low or pr_ready is high. While pr_valid is high and pr_ready is low, pr_valid and pr_taken hold steady. up_ready is always high.
- R11: An accepted lookup gives pr_valid = 1 on the next clock edge. No response is produced without an accepted lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| use_local | input | 1 | 0 = global history, 1 = per-slot local history |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request can be accepted |
| lk_addr | input | ADDR_W | Address of the branch to predict |
| pr_valid | output | 1 | Prediction response valid |
| pr_ready | input | 1 | Consumer takes the response |
| pr_taken | output | 1 | Predicted direction, 1 = taken |
| up_valid | input | 1 | Resolved-branch update valid |
| up_ready | output | 1 | Update accepted (always 1) |
| up_addr | input | ADDR_W | Address of the resolved branch |
| up_taken | input | 1 | Resolved direction, 1 = taken |

## Verification
A wrong counter value stays hidden until some later lookup lands on that exact entry. It then shows as an inverted pr_taken one cycle after that lookup is accepted. A history that shifts wrongly or in the wrong slot moves the index instead. This shows as wrong predictions on the very next lookup of any address in global mode, but only on the same slot in local mode. The bench keeps its own model of counters and histories and compares every response. It deliberately revisits the saturated entries, so that a hysteresis or wrap fault becomes visible within a few updates.

// File: rtl/bp_pkg.sv
package bp_pkg;
  typedef enum logic {
    HSRC_GLOBAL = 1'b0,
    HSRC_LOCAL  = 1'b1
  } hsrc_e;
endpackage

// File: rtl/bp_hist.sv
module bp_hist #(
  parameter int ADDR_W = 32,
  parameter int HIST_W = 4,
  parameter int LHT_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bp_pkg::hsrc_e     src,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wr_taken,
  output logic [HIST_W-1:0] rd_hist,
  output logic [HIST_W-1:0] wr_hist,
  output logic [HIST_W-1:0] ghist_o
);
  localparam int LHT_N = 1 << LHT_W;

  logic [HIST_W-1:0] ghist;
  logic [HIST_W-1:0] lhist [LHT_N];

  // Global pattern: every resolved branch shifts in, newest at bit 0.
  always_ff @(posedge clk) begin
    if (!rst_n) ghist <= '0;
    else if (wr_en) ghist <= {ghist[HIST_W-2:0], wr_taken};
  end

  // One local pattern register per low-address slot.
  for (genvar e = 0; e < LHT_N; e++) begin : g_lht
    always_ff @(posedge clk) begin
      if (!rst_n) lhist[e] <= '0;
      else if (wr_en && (wr_addr[LHT_W-1:0] == LHT_W'(e)))
        lhist[e] <= {lhist[e][HIST_W-2:0], wr_taken};
    end
  end

  always_comb begin
    rd_hist = (src == bp_pkg::HSRC_LOCAL) ? lhist[rd_addr[LHT_W-1:0]] : ghist;
    wr_hist = (src == bp_pkg::HSRC_LOCAL) ? lhist[wr_addr[LHT_W-1:0]] : ghist;
  end

  assign ghist_o = ghist;
endmodule

// File: rtl/bp_pht.sv
module bp_pht #(
  parameter int IDX_W = 8,
  parameter int CTR_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [CTR_W-1:0] rd_ctr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken
);
  localparam int N = 1 << IDX_W;
  localparam logic [CTR_W-1:0] CTR_MAX  = '1;
  localparam logic [CTR_W-1:0] CTR_INIT = CTR_W'((1 << (CTR_W - 1)) - 1);

  logic [CTR_W-1:0] tbl [N];
  logic [CTR_W-1:0] cur, nxt;

  // Read is taken from the current state: a same-cycle write lands after.
  assign rd_ctr = tbl[rd_idx];
  assign cur    = tbl[wr_idx];

  always_comb begin
    nxt = cur;
    if (wr_taken) begin
      if (cur != CTR_MAX) nxt = cur + 1'b1;
    end else begin
      if (cur != '0) nxt = cur - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) tbl[i] <= CTR_INIT;
    end else if (wr_en) begin
      tbl[wr_idx] <= nxt;
    end
  end
endmodule

// File: rtl/bpred_2lvl.sv
module bpred_2lvl #(
  parameter int ADDR_W  = 32,
  parameter int HIST_W  = 4,
  parameter int PC_BITS = 4,
  parameter int LHT_W   = 3,
  parameter int CTR_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              use_local,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              pr_valid,
  input  logic              pr_ready,
  output logic              pr_taken,
  input  logic              up_valid,
  output logic              up_ready,
  input  logic [ADDR_W-1:0] up_addr,
  input  logic              up_taken
);
  localparam int PHT_AW = HIST_W + PC_BITS;

  bp_pkg::hsrc_e     src;
  logic [HIST_W-1:0] rd_hist_w, wr_hist_w, ghist_w;
  logic [PHT_AW-1:0] rd_idx_w, wr_idx_w;
  logic [CTR_W-1:0]  rd_ctr_w;
  logic              lk_fire;

  assign src = use_local ? bp_pkg::HSRC_LOCAL : bp_pkg::HSRC_GLOBAL;

  bp_hist #(.ADDR_W(ADDR_W), .HIST_W(HIST_W), .LHT_W(LHT_W)) u_hist (
    .clk(clk), .rst_n(rst_n), .src(src),
    .rd_addr(lk_addr), .wr_en(up_valid), .wr_addr(up_addr), .wr_taken(up_taken),
    .rd_hist(rd_hist_w), .wr_hist(wr_hist_w), .ghist_o(ghist_w)
  );

  assign rd_idx_w = {rd_hist_w, lk_addr[PC_BITS-1:0]};
  assign wr_idx_w = {wr_hist_w, up_addr[PC_BITS-1:0]};

  bp_pht #(.IDX_W(PHT_AW), .CTR_W(CTR_W)) u_pht (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(rd_idx_w), .rd_ctr(rd_ctr_w),
    .wr_en(up_valid), .wr_idx(wr_idx_w), .wr_taken(up_taken)
  );

  assign lk_ready = !pr_valid || pr_ready;
  assign lk_fire  = lk_valid && lk_ready;
  assign up_ready = 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pr_valid <= 1'b0;
      pr_taken <= 1'b0;
    end else if (lk_fire) begin
      pr_valid <= 1'b1;
      pr_taken <= rd_ctr_w[CTR_W-1];
    end else if (pr_ready) begin
      pr_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/bp_checker.sv
module bp_checker #(
  parameter int HIST_W = 4,
  parameter int CTR_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lk_valid,
  input logic              lk_ready,
  input logic              pr_valid,
  input logic              pr_ready,
  input logic              pr_taken,
  input logic              up_valid,
  input logic              up_taken,
  input logic [HIST_W-1:0] ghist,
  input logic [CTR_W-1:0]  rd_ctr
);
  a_r10_hold_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (pr_valid && !pr_ready) |=> pr_valid);

  a_r10_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
    (pr_valid && !pr_ready) |=> $stable(pr_taken));

  a_r11_resp_next: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_ready) |=> pr_valid);

  a_r11_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    (!(lk_valid && lk_ready) && (!pr_valid || pr_ready)) |=> !pr_valid);

  a_r2_pred_msb: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_ready) |=> (pr_taken == $past(rd_ctr[CTR_W-1])));

  a_r6_ghist_shift: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid |=> (ghist == {$past(ghist[HIST_W-2:0]), $past(up_taken)}));

  a_r7_ghist_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !up_valid |=> $stable(ghist));
endmodule

bind bpred_2lvl bp_checker #(.HIST_W(HIST_W), .CTR_W(CTR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_ready(lk_ready),
  .pr_valid(pr_valid), .pr_ready(pr_ready), .pr_taken(pr_taken),
  .up_valid(up_valid), .up_taken(up_taken), .ghist(ghist_w), .rd_ctr(rd_ctr_w)
);

// File: tb/sim_bpred_2lvl.sv
module sim_bpred_2lvl;
  localparam int ADDR_W = 32, HIST_W = 4, PC_BITS = 4, LHT_W = 3, CTR_W = 2;
  localparam int PHT_N = 1 << (HIST_W + PC_BITS);
  localparam int LHT_N = 1 << LHT_W;
  localparam int CMAX = (1 << CTR_W) - 1;
  localparam int CHALF = 1 << (CTR_W - 1);

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, use_local, lk_valid, lk_ready, pr_valid, pr_ready, pr_taken;
  logic up_valid, up_ready, up_taken;
  logic [ADDR_W-1:0] lk_addr, up_addr;

  bpred_2lvl #(.ADDR_W(ADDR_W), .HIST_W(HIST_W), .PC_BITS(PC_BITS),
               .LHT_W(LHT_W), .CTR_W(CTR_W)) u0 (
    .clk(clk), .rst_n(rst_n), .use_local(use_local),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_addr(lk_addr),
    .pr_valid(pr_valid), .pr_ready(pr_ready), .pr_taken(pr_taken),
    .up_valid(up_valid), .up_ready(up_ready), .up_addr(up_addr), .up_taken(up_taken)
  );

  int n_chk = 0, n_err = 0;
  string cur_tag = "R1";
  bit    expq[$];
  string tagq[$];

  int          m_ctr [PHT_N];
  logic [HIST_W-1:0] m_g;
  logic [HIST_W-1:0] m_l [LHT_N];

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  // R5: index = {history, low address bits}; R7/R8 choose the history.
  function automatic int m_idx(logic [ADDR_W-1:0] a, logic loc);
    logic [HIST_W-1:0] h;
    h = loc ? m_l[a[LHT_W-1:0]] : m_g;
    return int'({h, a[PC_BITS-1:0]});
  endfunction

  function automatic void m_update(logic [ADDR_W-1:0] a, logic t, logic loc);
    int i;
    i = m_idx(a, loc);
    if (t && m_ctr[i] < CMAX) m_ctr[i]++;           // R3
    if (!t && m_ctr[i] > 0) m_ctr[i]--;             // R4
    m_g = {m_g[HIST_W-2:0], t};                      // R6
    m_l[a[LHT_W-1:0]] = {m_l[a[LHT_W-1:0]][HIST_W-2:0], t};  // R8
  endfunction

  // Driver: one cycle of stimulus; pushes the expected prediction.
  task automatic step(bit dl, int la, bit du, int ua, bit ut);
    bit acc;
    @(negedge clk);
    lk_valid = dl; lk_addr = ADDR_W'(la);
    up_valid = du; up_addr = ADDR_W'(ua); up_taken = ut;
    #1;
    acc = dl && lk_ready;
    if (acc) begin
      // R9: expectation taken before the same-cycle update is applied
      expq.push_back(m_ctr[m_idx(ADDR_W'(la), use_local)] >= CHALF);
      tagq.push_back(cur_tag);
    end
    if (du) m_update(ADDR_W'(ua), ut, use_local);
    @(posedge clk); #1;
    lk_valid = 1'b0; up_valid = 1'b0;
    if (acc) chk("R11 latency", int'(pr_valid), 1);
  endtask

  // Monitor: pops and compares as responses are taken.
  initial begin
    forever begin
      @(negedge clk); #2;
      if (rst_n && pr_valid && pr_ready) begin
        if (expq.size() == 0) chk("R11 unexpected response", 1, 0);
        else begin
          bit e; string t;
          e = expq.pop_front(); t = tagq.pop_front();
          chk(t, int'(pr_taken), int'(e));
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    report();
  end

  initial begin
    rst_n = 1'b0; use_local = 1'b0; lk_valid = 1'b0; pr_ready = 1'b1;
    up_valid = 1'b0; up_taken = 1'b0; lk_addr = '0; up_addr = '0;
    for (int i = 0; i < PHT_N; i++) m_ctr[i] = CHALF - 1;
    m_g = '0;
    for (int i = 0; i < LHT_N; i++) m_l[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1; #1;
    chk("R1 pr_valid after reset", int'(pr_valid), 0);
    chk("R10 lk_ready after reset", int'(lk_ready), 1);
    chk("R10 up_ready", int'(up_ready), 1);

    // R1: untrained table predicts not-taken everywhere
    cur_tag = "R1";
    for (int a = 0; a < 8; a++) step(1, a * 37, 0, 0, 0);

    // R2/R3: global mode, train address 5 taken until saturated
    cur_tag = "R3";
    for (int n = 0; n < 10; n++) begin
      step(0, 0, 1, 5, 1);
      step(1, 5, 0, 0, 0);
    end
    // R4: one miss from saturation, restore pattern, still taken
    cur_tag = "R4";
    step(0, 0, 1, 5, 0);
    for (int n = 0; n < HIST_W; n++) step(0, 0, 1, 5, 1);
    step(1, 5, 0, 0, 0);
    // second miss on the same entry flips it
    step(0, 0, 1, 5, 0);
    for (int n = 0; n < HIST_W; n++) step(0, 0, 1, 5, 1);
    step(1, 5, 0, 0, 0);

    // R4 low side: saturate at zero, one taken must not flip
    cur_tag = "R4 low";
    for (int n = 0; n < 10; n++) begin
      step(0, 0, 1, 9, 0);
      step(1, 9, 0, 0, 0);
    end
    step(0, 0, 1, 9, 1);
    for (int n = 0; n < HIST_W; n++) step(0, 0, 1, 9, 0);
    step(1, 9, 0, 0, 0);

    // R7: global history from one branch steers another
    cur_tag = "R7";
    for (int n = 0; n < 6; n++) begin
      step(0, 0, 1, 1, n[0]);
      step(1, 2, 0, 0, 0);
      step(1, 1, 0, 0, 0);
    end

    // R8: local mode, slot 3 trained, slot 4 untouched
    cur_tag = "R8";
    use_local = 1'b1;
    for (int n = 0; n < 8; n++) begin
      step(0, 0, 1, 3, 1);
      step(1, 3, 0, 0, 0);
      step(1, 4, 0, 0, 0);
    end
    for (int n = 0; n < 6; n++) begin
      step(0, 0, 1, 12, n[1]);
      step(1, 12, 0, 0, 0);
      step(1, 11, 0, 0, 0);
    end
    use_local = 1'b0;
    step(1, 3, 0, 0, 0);

    // R9: lookup and update on the same entry in one cycle
    cur_tag = "R9";
    for (int n = 0; n < 6; n++) step(1, 6, 1, 6, 1);
    for (int n = 0; n < 6; n++) step(1, 6, 1, 6, 0);

    // R10: back-pressure holds the response
    cur_tag = "R10";
    @(negedge clk); pr_ready = 1'b0;
    step(1, 5, 0, 0, 0);
    begin
      logic held;
      @(negedge clk); #1;
      held = pr_taken;
      chk("R10 lk_ready low while stalled", int'(lk_ready), 0);
      step(1, 8, 0, 0, 0);
      for (int n = 0; n < 3; n++) begin
        @(negedge clk); #1;
        chk("R10 pr_valid held", int'(pr_valid), 1);
        chk("R10 pr_taken held", int'(pr_taken), int'(held));
      end
    end
    @(negedge clk); pr_ready = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    chk("R11 queue drained", expq.size(), 0);
    chk("R11 no response left", int'(pr_valid), 0);
    report();
  end
endmodule